// File: doc/BRIEF.md
# SCL Clock Waveform Generator

This block produces the serial clock for a two-wire bus master. It counts the system clock to build a low phase and a high phase, each with its own length, and emits one-cycle strobes in the middle of each phase: the one in the low phase tells the bus state machine where to change SDA, and the one in the high phase tells it where to sample SDA. Each phase lasts `divider * 2^exponent + OFFSET` system clock cycles. The low and high dividers are set independently, and a single prescaler exponent applies to both. With the default build (`OFFSET` = 3, `EXP_MAX` = 5) the generator covers the usual 100 kHz and 400 kHz bus rates from common system clocks.

The master drives `run_i` while a transfer is in progress. When the generator is idle it keeps SCL high. Raising `run_i` starts a low phase, which stands for the start of a transfer. Lowering `run_i` lets the current period finish through its high phase before the generator parks. `en_i` is a hard enable: dropping it parks SCL at once. The configuration word is sampled only where a phase begins, so a write can never cut a phase short and produce a runt pulse.

Top module: `scl_wave_gen`

## Requirements
- R1: After reset, and whenever the generator is idle, `scl_o` is 1, `phase_o` is 2'b00 (idle), and neither tick output is asserted. The encoding is 00 idle, 01 low, 10 high.
- R2: The configuration word holds three fields. `cfg_i[7:0]` is the low-phase divider, `cfg_i[15:8]` is the high-phase divider, and `cfg_i[18:16]` is the prescaler exponent shared by both phases.
- R3: A low phase lasts `lo_div * 2^exp + OFFSET` cycles with `scl_o` at 0. A high phase lasts `hi_div * 2^exp + OFFSET` cycles with `scl_o` at 1. The default `OFFSET` is 3, so a divider of 0 gives a 3-cycle phase.
- R4: An exponent field above `EXP_MAX` (default 5) is treated as `EXP_MAX`.
- R5: When `en_i` and `run_i` are both 1 while the generator is idle, a low phase begins at the next clock edge.
- R6: `drv_tick_o` is asserted for exactly one cycle in each low phase. It falls at cycle index floor(len/2), where index 0 is the first cycle of the phase.
- R7: `smp_tick_o` is asserted for exactly one cycle in each high phase. It falls at cycle index floor(len/2) of that phase.
- R8: The length of a phase is taken from `cfg_i` as it stands in the last cycle of the preceding phase (or in the idle cycle where the start is seen). A change to `cfg_i` during a phase has no effect on that phase.
- R9: If `run_i` is 0 when a low phase ends, the following high phase still runs in full. If `run_i` is 0 when a high phase ends, the generator returns to idle instead of starting a new low phase.
- R10: When `en_i` is 0, the generator is idle from the next clock edge and its cycle count is cleared. A later start therefore begins with a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master enable; 0 parks the generator at once |
| run_i | input | 1 | Transfer active; a rising level starts clocking |
| cfg_i | input | 19 | Low divider [7:0], high divider [15:8], exponent [18:16] |
| scl_o | output | 1 | Generated serial clock level |
| phase_o | output | 2 | Current phase: 00 idle, 01 low, 10 high |
| drv_tick_o | output | 1 | Mid-low strobe for SDA updates |
| smp_tick_o | output | 1 | Mid-high strobe for SDA sampling |

## Verification
A configuration write can land in the same cycle as a phase boundary, and the bench tests exactly that case. It changes `cfg_i` at the negedge before the last low cycle's closing edge, and the high phase that follows must take the new high length. It then writes the old value back during the first cycle of that high phase, which must keep its length; the old value applies only to the next low phase. A second collision, a drop of `en_i` in the middle of a low phase, is judged by the generator parking on the next edge and then starting a full-length low phase on the next run.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_LOW  = 2'b01,
    PH_HIGH = 2'b10
  } phase_e;

  localparam int unsigned LO_SEL = 0;
  localparam int unsigned HI_SEL = 1;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned EXP_W   = 3,
  parameter int unsigned EXP_MAX = 5,
  localparam int unsigned CFG_W  = 2 * DIV_W + EXP_W
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic [DIV_W-1:0] lo_div_o,
  output logic [DIV_W-1:0] hi_div_o,
  output logic [EXP_W-1:0] exp_o
);
  logic [EXP_W-1:0] exp_raw;

  assign lo_div_o = cfg_i[DIV_W-1:0];
  assign hi_div_o = cfg_i[2*DIV_W-1:DIV_W];
  assign exp_raw  = cfg_i[CFG_W-1:2*DIV_W];

  // clamp to the variant's prescaler range
  always_comb begin
    if (exp_raw > EXP_W'(EXP_MAX)) exp_o = EXP_W'(EXP_MAX);
    else                           exp_o = exp_raw;
  end

  // R4 clamp never exceeds the build limit
  always_comb begin
    if (!$isunknown(cfg_i))
      a_r4_exp_sat: assert (exp_o <= EXP_W'(EXP_MAX));
  end
endmodule

// File: rtl/scl_len_calc.sv
module scl_len_calc #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned EXP_W   = 3,
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned OFFSET  = 3
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [CNT_W-1:0] len_o
);
  assign len_o = (CNT_W'(div_i) << exp_i) + CNT_W'(OFFSET);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned OFFSET = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_lo_i,
  input  logic [CNT_W-1:0] len_hi_i,
  output phase_e           phase_o,
  output logic             drv_tick_o,
  output logic             smp_tick_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             last_c;
  logic             mid_c;

  assign last_c = (cnt_q == len_q - CNT_W'(1));
  assign mid_c  = (cnt_q == (len_q >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (run_i) begin
            phase_q <= PH_LOW;
            len_q   <= len_lo_i;
          end
        end
        PH_LOW: begin
          if (last_c) begin
            phase_q <= PH_HIGH;
            len_q   <= len_hi_i;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (last_c) begin
            cnt_q <= '0;
            if (run_i) begin
              phase_q <= PH_LOW;
              len_q   <= len_lo_i;
            end else begin
              phase_q <= PH_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign drv_tick_o = (phase_q == PH_LOW)  && mid_c;
  assign smp_tick_o = (phase_q == PH_HIGH) && mid_c;

  // R3 counter stays inside the latched phase length
  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |-> (cnt_q < len_q));

  // R3 an active phase is never shorter than the offset
  a_r3_len_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |-> (len_q >= CNT_W'(OFFSET)));

  // R8 phase length frozen after the first cycle of a phase
  a_r8_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && cnt_q != '0) |-> $stable(len_q));

  // R10 disable parks on the next edge
  a_r10_en_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_q == PH_IDLE && cnt_q == '0));

  // R5 start from idle enters the low phase
  a_r5_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && en_i && run_i) |=> (phase_q == PH_LOW && cnt_q == '0));
endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned EXP_W   = 3,
  parameter int unsigned EXP_MAX = 5,
  parameter int unsigned OFFSET  = 3,
  localparam int unsigned CFG_W  = 2 * DIV_W + EXP_W,
  localparam int unsigned CNT_W  = DIV_W + EXP_MAX + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             scl_o,
  output logic [1:0]       phase_o,
  output logic             drv_tick_o,
  output logic             smp_tick_o
);
  logic [DIV_W-1:0] div_c [2];
  logic [CNT_W-1:0] len_c [2];
  logic [EXP_W-1:0] exp_c;
  phase_e           phase_c;

  scl_cfg_decode #(
    .DIV_W  (DIV_W),
    .EXP_W  (EXP_W),
    .EXP_MAX(EXP_MAX)
  ) u_dec (
    .cfg_i   (cfg_i),
    .lo_div_o(div_c[LO_SEL]),
    .hi_div_o(div_c[HI_SEL]),
    .exp_o   (exp_c)
  );

  for (genvar g = 0; g < 2; g++) begin : g_len
    scl_len_calc #(
      .DIV_W (DIV_W),
      .EXP_W (EXP_W),
      .CNT_W (CNT_W),
      .OFFSET(OFFSET)
    ) u_len (
      .div_i(div_c[g]),
      .exp_i(exp_c),
      .len_o(len_c[g])
    );
  end

  scl_phase_fsm #(
    .CNT_W (CNT_W),
    .OFFSET(OFFSET)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .run_i     (run_i),
    .len_lo_i  (len_c[LO_SEL]),
    .len_hi_i  (len_c[HI_SEL]),
    .phase_o   (phase_c),
    .drv_tick_o(drv_tick_o),
    .smp_tick_o(smp_tick_o)
  );

  assign phase_o = phase_c;
  assign scl_o   = (phase_c != PH_LOW);

  // R1 idle keeps the line high and quiet
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b00) |-> (scl_o && !drv_tick_o && !smp_tick_o));

  // R6 drive strobe only while SCL is low
  a_r6_drv_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_tick_o |-> !scl_o);

  // R7 sample strobe only while SCL is high and active
  a_r7_smp_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_tick_o |-> (scl_o && phase_o == 2'b10));

  // R6 R7 strobes never coincide
  a_r6_tick_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_tick_o && smp_tick_o));

  // R9 the high phase always follows a low phase
  a_r9_low_to_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $fell(phase_o == 2'b01)) |-> (phase_o == 2'b10));
endmodule

// File: tb/scl_wave_gen_tb.sv
module scl_wave_gen_tb;
  typedef struct packed {
    logic [18:0] cfg;
    logic [15:0] lo_len;
    logic [15:0] hi_len;
  } vec_t;

  // cfg = {exp, hi_div, lo_div}; OFFSET 3, EXP_MAX 5
  localparam vec_t VEC [7] = '{
    '{cfg: {3'd0, 8'd5,  8'd2},   lo_len: 16'd5,    hi_len: 16'd8},
    '{cfg: {3'd3, 8'd1,  8'd1},   lo_len: 16'd11,   hi_len: 16'd11},
    '{cfg: {3'd0, 8'd0,  8'd0},   lo_len: 16'd3,    hi_len: 16'd3},
    '{cfg: {3'd7, 8'd2,  8'd3},   lo_len: 16'd99,   hi_len: 16'd67},
    '{cfg: {3'd2, 8'd20, 8'd10},  lo_len: 16'd43,   hi_len: 16'd83},
    '{cfg: {3'd6, 8'd1,  8'd255}, lo_len: 16'd8163, hi_len: 16'd35},
    '{cfg: {3'd5, 8'd4,  8'd0},   lo_len: 16'd3,    hi_len: 16'd131}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        run_i = 1'b0;
  logic [18:0] cfg_i = '0;
  logic        scl_o;
  logic [1:0]  phase_o;
  logic        drv_tick_o;
  logic        smp_tick_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  scl_wave_gen u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .run_i     (run_i),
    .cfg_i     (cfg_i),
    .scl_o     (scl_o),
    .phase_o   (phase_o),
    .drv_tick_o(drv_tick_o),
    .smp_tick_o(smp_tick_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count cycles of one phase from the current negedge; tick position and count
  task automatic observe(input logic [1:0] ph, output int len, output int tpos, output int ntk);
    len = 0; tpos = -1; ntk = 0;
    while (phase_o == ph && len < 20000) begin
      if ((ph == 2'b01 && drv_tick_o) || (ph == 2'b10 && smp_tick_o)) begin
        tpos = len;
        ntk++;
      end
      if (ph == 2'b01 && scl_o !== 1'b0) chk(1'b0, "R3 scl low", int'(scl_o), 0);
      len++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    #1_500_000ns;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int len, tpos, ntk;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(scl_o === 1'b1, "R1 scl in reset", int'(scl_o), 1);
    chk(phase_o === 2'b00, "R1 phase in reset", int'(phase_o), 0);
    chk(!drv_tick_o && !smp_tick_o, "R1 ticks in reset", int'({drv_tick_o, smp_tick_o}), 0);
    rst_ni = 1'b1;
    en_i   = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(phase_o === 2'b00 && scl_o === 1'b1, "R1 idle after reset", int'(phase_o), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < 7; i++) begin
      cfg_i = VEC[i].cfg;
      @(negedge clk_i);
      run_i = 1'b1;
      @(negedge clk_i);
      chk(phase_o === 2'b01 && scl_o === 1'b0, "R5 low after start", int'(phase_o), 1);
      observe(2'b01, len, tpos, ntk);
      chk(len == int'(VEC[i].lo_len), "R3 R4 low length", len, int'(VEC[i].lo_len));
      chk(tpos == int'(VEC[i].lo_len) / 2 && ntk == 1, "R6 drive tick", tpos, int'(VEC[i].lo_len) / 2);
      observe(2'b10, len, tpos, ntk);
      chk(len == int'(VEC[i].hi_len), "R3 R4 high length", len, int'(VEC[i].hi_len));
      chk(tpos == int'(VEC[i].hi_len) / 2 && ntk == 1, "R7 sample tick", tpos, int'(VEC[i].hi_len) / 2);
      run_i = 1'b0;
      // R9 drop in low: low and high both finish
      observe(2'b01, len, tpos, ntk);
      chk(len == int'(VEC[i].lo_len), "R9 low completes", len, int'(VEC[i].lo_len));
      observe(2'b10, len, tpos, ntk);
      chk(len == int'(VEC[i].hi_len), "R9 high completes", len, int'(VEC[i].hi_len));
      chk(phase_o === 2'b00 && scl_o === 1'b1, "R9 parked after high", int'(phase_o), 0);
    end

    // R10 abrupt disable mid low, then full restart
    cfg_i = VEC[4].cfg;
    run_i = 1'b1;
    @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(phase_o === 2'b00 && scl_o === 1'b1, "R10 park on disable", int'(phase_o), 0);
    repeat (3) @(negedge clk_i);
    chk(phase_o === 2'b00, "R10 held while disabled", int'(phase_o), 0);
    en_i = 1'b1;
    @(negedge clk_i);
    observe(2'b01, len, tpos, ntk);
    chk(len == 43, "R10 full low after restart", len, 43);
    run_i = 1'b0;
    observe(2'b10, len, tpos, ntk);
    chk(phase_o === 2'b00, "R9 idle after restart", int'(phase_o), 0);

    // R8 write on the boundary cycle, then write inside a phase
    cfg_i = VEC[0].cfg;
    run_i = 1'b1;
    @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(phase_o === 2'b01, "R8 still in last low cycle", int'(phase_o), 1);
    cfg_i = VEC[1].cfg;
    @(negedge clk_i);
    chk(phase_o === 2'b10, "R8 high started", int'(phase_o), 2);
    cfg_i = VEC[0].cfg;
    observe(2'b10, len, tpos, ntk);
    chk(len == 11, "R8 boundary write governs high", len, 11);
    observe(2'b01, len, tpos, ntk);
    chk(len == 5, "R8 mid-phase write waits for boundary", len, 5);
    run_i = 1'b0;
    observe(2'b10, len, tpos, ntk);
    chk(len == 8, "R8 high from restored cfg", len, 8);

    // R2 field independence: only high divider changes
    cfg_i = {3'd1, 8'd9, 8'd4};
    run_i = 1'b1;
    @(negedge clk_i);
    observe(2'b01, len, tpos, ntk);
    chk(len == 11, "R2 low field", len, 11);
    run_i = 1'b0;
    observe(2'b10, len, tpos, ntk);
    chk(len == 21, "R2 high field", len, 21);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule